// File: doc/BRIEF.md
# Function Event Register Bank

This block holds the event status and event mask state for each function of a multi-function expansion card. Each function has a general wakeup pending bit, an interrupt pending view and a set of mask bits. The pending view is built from four interrupt source latches. All of this state is read and written through one 16-bit register port. Each function occupies its own 16-byte slot in the base-address region. A function's slot also carries a read-only view of its interrupt source latches and the address pointer word that the card's configuration data stores for that function.

Wakeup events come from an audio-link wake input and a GPIO wake input, each qualified by its own enable. A qualified event latches the wakeup pending bit, and software clears that bit by writing one to it. Interrupt sources latch on their own. The interrupt pending bit is the masked OR of those latches, and writing one to it clears all four latches together. Three synchronous reset inputs act on different subsets of bits. The power-on reset clears everything. The bus reset spares the wakeup state. The system/soft reset also spares the interrupt latches. Each function drives a status-change (wakeup) output that is active only in CardBus mode, and only when both the master wakeup enable and the wakeup mask are set.

Top module: `fe_event_bank`

## Requirements
- R1: With the default base 0x100, function n (0 to 2) has its slot at 0x100 + 0x10·n. Inside the slot, offset +0x0 is the event register, +0x4 the mask register, +0x8 the source status and +0xC the pointer word. The pointer word reads as the event register offset with bit 0 set: 0x0101, 0x0111, 0x0121. Any other address reads 0 and a write to it changes nothing.
- R2: In the event register only bit 4 (wakeup pending) and bit 15 (interrupt pending) can read 1. In the mask register only bit 4 (wakeup mask), bit 14 (master wakeup enable) and bit 15 (interrupt mask) can read 1. Writes to all other bits are ignored. In the source status, latch i reads at bit 12+i and all other bits read 0.
- R3: Wakeup pending is set in the cycle after audio wake is high together with its enable, or GPIO wake is high together with its enable. A wake input whose enable is low does not set it.
- R4: Writing 1 to event bit 4 clears wakeup pending. Writing 0 to it leaves it unchanged.
- R5: Wakeup pending and the master wakeup enable are cleared only by the power-on reset. Bus reset and system reset leave both unchanged.
- R6: Event bit 15 and the intr_pend output equal the OR of the four source latches ANDed with the interrupt mask.
- R7: A high source input sets its latch in the next cycle. Writing 1 to event bit 15 clears all four latches of that function.
- R8: The source latches are cleared by power-on reset and by bus reset. System reset leaves them unchanged.
- R9: The wakeup mask and the interrupt mask are cleared by any of the three resets.
- R10: stschg for a function is high exactly when cardbus_mode, the master wakeup enable, the wakeup mask and wakeup pending are all 1.
- R11: When a set event and a write-one clear of the same bit fall in the same cycle, the bit ends up set. This applies both to wakeup pending and to each source latch.
- R12: A register write changes only the function whose slot it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears all state |
| bus_rst | input | 1 | Bus reset, synchronous, active high; clears masks and source latches |
| sys_rst | input | 1 | System/soft reset, synchronous, active high; clears masks only |
| cardbus_mode | input | 1 | High when the card runs in CardBus mode |
| aud_wake | input | NUM_FUNC | Audio-link wake event, one bit per function |
| aud_wake_en | input | NUM_FUNC | Enable for the audio-link wake, one bit per function |
| gpio_wake | input | NUM_FUNC | GPIO wake event, one bit per function |
| gpio_wake_en | input | NUM_FUNC | Enable for the GPIO wake, one bit per function |
| irq_src | input | NUM_FUNC*4 | Interrupt source inputs; function f uses bits 4f+3:4f |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address within the base-address region |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| stschg | output | NUM_FUNC | Status-change / wakeup output per function |
| intr_pend | output | NUM_FUNC | Masked interrupt pending per function |

## Verification
Two things can land in the same cycle: a set event, and a write-one clear of the same bit. This applies to the wakeup pending bit and to the interrupt source latches. The bench provokes the collision by holding a qualified wake input, or an interrupt source, high during the very clock edge that carries the clearing register write. It judges the result by reading the bit back over the register port: the bit must still be 1. Latches of the same function whose source was low must be cleared by that same write.

// File: rtl/fe_bank_pkg.sv
package fe_bank_pkg;

    localparam int REG_W       = 16;
    localparam int NUM_IRQ     = 4;
    localparam int SLOT_BYTES  = 16;
    localparam int SLOT_LSB    = $clog2(SLOT_BYTES);

    // bit positions decoded by software
    localparam int WAKE_BIT    = 4;
    localparam int MASTER_BIT  = 14;
    localparam int INTR_BIT    = 15;
    localparam int SRC_LSB     = REG_W - NUM_IRQ;

    // register selector taken from address bits 3:2 within a slot
    typedef enum logic [1:0] {
        SEL_EVENT = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_SRC   = 2'd2,
        SEL_PTR   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic intr_pend;
        logic wake_pend;
    } evt_t;

    typedef struct packed {
        logic intr_mask;
        logic master_wake;
        logic wake_mask;
    } mask_t;

    typedef struct packed {
        logic wr_evt;
        logic wr_mask;
    } wr_strb_t;

    function automatic logic [REG_W-1:0] pack_event(input evt_t e);
        logic [REG_W-1:0] w;
        w = '0;
        w[WAKE_BIT] = e.wake_pend;
        w[INTR_BIT] = e.intr_pend;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_mask(input mask_t m);
        logic [REG_W-1:0] w;
        w = '0;
        w[WAKE_BIT]   = m.wake_mask;
        w[MASTER_BIT] = m.master_wake;
        w[INTR_BIT]   = m.intr_mask;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_src(input logic [NUM_IRQ-1:0] l);
        logic [REG_W-1:0] w;
        w = '0;
        w[SRC_LSB +: NUM_IRQ] = l;
        return w;
    endfunction

    // location word stored in the card's configuration data: offset with bit 0 set
    function automatic logic [REG_W-1:0] pointer_word(input int unsigned slot_offset);
        logic [REG_W-1:0] w;
        w = REG_W'(slot_offset);
        w[0] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/fe_wake_unit.sv
module fe_wake_unit
    import fe_bank_pkg::*;
(
    input  logic clk,
    input  logic por_rst,
    input  logic bus_rst,
    input  logic sys_rst,
    input  logic cardbus_mode,
    input  logic aud_wake,
    input  logic aud_wake_en,
    input  logic gpio_wake,
    input  logic gpio_wake_en,
    input  logic wr_evt,
    input  logic wr_mask,
    input  logic wd_wake_clr,
    input  logic wd_wake_mask,
    input  logic wd_master,
    output logic wake_pend,
    output logic wake_mask,
    output logic master_wake,
    output logic stschg
);

    logic set_evt;
    logic clr_evt;
    logic any_rst;

    assign set_evt = (aud_wake & aud_wake_en) | (gpio_wake & gpio_wake_en);
    assign clr_evt = wr_evt & wd_wake_clr;
    assign any_rst = por_rst | bus_rst | sys_rst;

    // pending bit lives in the power-on-only domain; set beats clear
    always_ff @(posedge clk) begin
        if (por_rst)
            wake_pend <= 1'b0;
        else if (set_evt)
            wake_pend <= 1'b1;
        else if (clr_evt)
            wake_pend <= 1'b0;
    end

    // master enable also survives bus and system reset
    always_ff @(posedge clk) begin
        if (por_rst)
            master_wake <= 1'b0;
        else if (wr_mask)
            master_wake <= wd_master;
    end

    // ordinary mask bit: any reset clears it
    always_ff @(posedge clk) begin
        if (any_rst)
            wake_mask <= 1'b0;
        else if (wr_mask)
            wake_mask <= wd_wake_mask;
    end

    assign stschg = cardbus_mode & master_wake & wake_mask & wake_pend;

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (por_rst)
        set_evt |=> wake_pend)
        else $error("wake set lost");

    assert_hold_wake_R5: assert property (@(posedge clk) disable iff (por_rst)
        (!set_evt && !clr_evt) |=> $stable(wake_pend))
        else $error("wake pending changed without cause");

    assert_clear_wake_R4: assert property (@(posedge clk) disable iff (por_rst)
        (clr_evt && !set_evt) |=> !wake_pend)
        else $error("wake clear ignored");

    assert_master_keep_R5: assert property (@(posedge clk) disable iff (por_rst)
        !wr_mask |=> $stable(master_wake))
        else $error("master enable changed without write");

    assert_mask_reset_R9: assert property (@(posedge clk) disable iff (por_rst)
        (bus_rst || sys_rst) |=> !wake_mask)
        else $error("wake mask survived reset");

endmodule

// File: rtl/fe_irq_unit.sv
module fe_irq_unit
    import fe_bank_pkg::*;
(
    input  logic               clk,
    input  logic               por_rst,
    input  logic               bus_rst,
    input  logic               sys_rst,
    input  logic [NUM_IRQ-1:0] irq_src,
    input  logic               wr_evt,
    input  logic               wr_mask,
    input  logic               wd_intr_clr,
    input  logic               wd_intr_mask,
    output logic [NUM_IRQ-1:0] src_lat,
    output logic               intr_mask,
    output logic               intr_pend
);

    logic clr_all;
    logic lat_rst;
    logic any_rst;

    assign clr_all = wr_evt & wd_intr_clr;
    assign lat_rst = por_rst | bus_rst;
    assign any_rst = por_rst | bus_rst | sys_rst;

    // one latch per source; a source in the same cycle as the clear wins
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lat
        always_ff @(posedge clk) begin
            if (lat_rst)
                src_lat[i] <= 1'b0;
            else if (irq_src[i])
                src_lat[i] <= 1'b1;
            else if (clr_all)
                src_lat[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (any_rst)
            intr_mask <= 1'b0;
        else if (wr_mask)
            intr_mask <= wd_intr_mask;
    end

    assign intr_pend = (|src_lat) & intr_mask;

    assert_bus_clears_R8: assert property (@(posedge clk) disable iff (por_rst)
        bus_rst |=> (src_lat == '0))
        else $error("latches survived bus reset");

    assert_sys_keeps_R8: assert property (@(posedge clk) disable iff (por_rst)
        (sys_rst && !bus_rst && !clr_all) |=> (src_lat == ($past(src_lat) | $past(irq_src))))
        else $error("system reset touched latches");

    assert_clear_all_R7: assert property (@(posedge clk) disable iff (por_rst)
        (clr_all && !bus_rst) |=> (src_lat == $past(irq_src)))
        else $error("write-one clear left stale latches");

    assert_src_sets_R11: assert property (@(posedge clk) disable iff (por_rst)
        (!bus_rst && (|irq_src)) |=> ((src_lat & $past(irq_src)) == $past(irq_src)))
        else $error("source event lost");

    assert_mask_reset_R9: assert property (@(posedge clk) disable iff (por_rst)
        (bus_rst || sys_rst) |=> !intr_mask)
        else $error("interrupt mask survived reset");

endmodule

// File: rtl/fe_func_slice.sv
module fe_func_slice
    import fe_bank_pkg::*;
(
    input  logic               clk,
    input  logic               por_rst,
    input  logic               bus_rst,
    input  logic               sys_rst,
    input  logic               cardbus_mode,
    input  logic               aud_wake,
    input  logic               aud_wake_en,
    input  logic               gpio_wake,
    input  logic               gpio_wake_en,
    input  logic [NUM_IRQ-1:0] irq_src,
    input  wr_strb_t           strb,
    input  logic               wd_wake,
    input  logic               wd_master,
    input  logic               wd_intr,
    output evt_t               evt,
    output mask_t              mask,
    output logic [NUM_IRQ-1:0] src_lat,
    output logic               stschg,
    output logic               intr_pend
);

    logic wake_pend;
    logic wake_mask;
    logic master_wake;
    logic intr_mask;

    fe_wake_unit u_wake (
        .clk          (clk),
        .por_rst      (por_rst),
        .bus_rst      (bus_rst),
        .sys_rst      (sys_rst),
        .cardbus_mode (cardbus_mode),
        .aud_wake     (aud_wake),
        .aud_wake_en  (aud_wake_en),
        .gpio_wake    (gpio_wake),
        .gpio_wake_en (gpio_wake_en),
        .wr_evt       (strb.wr_evt),
        .wr_mask      (strb.wr_mask),
        .wd_wake_clr  (wd_wake),
        .wd_wake_mask (wd_wake),
        .wd_master    (wd_master),
        .wake_pend    (wake_pend),
        .wake_mask    (wake_mask),
        .master_wake  (master_wake),
        .stschg       (stschg)
    );

    fe_irq_unit u_irq (
        .clk          (clk),
        .por_rst      (por_rst),
        .bus_rst      (bus_rst),
        .sys_rst      (sys_rst),
        .irq_src      (irq_src),
        .wr_evt       (strb.wr_evt),
        .wr_mask      (strb.wr_mask),
        .wd_intr_clr  (wd_intr),
        .wd_intr_mask (wd_intr),
        .src_lat      (src_lat),
        .intr_mask    (intr_mask),
        .intr_pend    (intr_pend)
    );

    always_comb begin
        evt.wake_pend    = wake_pend;
        evt.intr_pend    = intr_pend;
        mask.wake_mask   = wake_mask;
        mask.master_wake = master_wake;
        mask.intr_mask   = intr_mask;
    end

    assert_stschg_gate_R10: assert property (@(posedge clk) disable iff (por_rst)
        stschg |-> (mask.master_wake && mask.wake_mask && evt.wake_pend))
        else $error("status change without all enables");

endmodule

// File: rtl/fe_event_bank.sv
module fe_event_bank
    import fe_bank_pkg::*;
#(
    parameter int NUM_FUNC = 3,
    parameter int ADDR_W   = 12,
    parameter int EVT_BASE = 'h100
) (
    input  logic                    clk,
    input  logic                    por_rst,
    input  logic                    bus_rst,
    input  logic                    sys_rst,
    input  logic                    cardbus_mode,
    input  logic [NUM_FUNC-1:0]     aud_wake,
    input  logic [NUM_FUNC-1:0]     aud_wake_en,
    input  logic [NUM_FUNC-1:0]     gpio_wake,
    input  logic [NUM_FUNC-1:0]     gpio_wake_en,
    input  logic [NUM_FUNC*4-1:0]   irq_src,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic [NUM_FUNC-1:0]     stschg,
    output logic [NUM_FUNC-1:0]     intr_pend
);

    localparam int TAG_W = ADDR_W - SLOT_LSB;

    reg_sel_e                 sel;
    logic                     word_ok;
    logic [NUM_FUNC-1:0]      hit;
    wr_strb_t                 strb   [NUM_FUNC];
    evt_t                     evt    [NUM_FUNC];
    mask_t                    mask   [NUM_FUNC];
    logic [NUM_IRQ-1:0]       src_lat[NUM_FUNC];
    logic [REG_W-1:0]         slot_rd[NUM_FUNC];

    assign sel     = reg_sel_e'(reg_addr[3:2]);
    assign word_ok = (reg_addr[1:0] == 2'b00);

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        localparam int            SLOT_OFF = EVT_BASE + f * SLOT_BYTES;
        localparam logic [ADDR_W-1:0] SLOT_ADR = ADDR_W'(SLOT_OFF);

        assign hit[f] = word_ok && (reg_addr[ADDR_W-1:SLOT_LSB] == SLOT_ADR[ADDR_W-1:SLOT_LSB]);

        always_comb begin
            strb[f].wr_evt  = reg_wr && hit[f] && (sel == SEL_EVENT);
            strb[f].wr_mask = reg_wr && hit[f] && (sel == SEL_MASK);
        end

        fe_func_slice u_slice (
            .clk          (clk),
            .por_rst      (por_rst),
            .bus_rst      (bus_rst),
            .sys_rst      (sys_rst),
            .cardbus_mode (cardbus_mode),
            .aud_wake     (aud_wake[f]),
            .aud_wake_en  (aud_wake_en[f]),
            .gpio_wake    (gpio_wake[f]),
            .gpio_wake_en (gpio_wake_en[f]),
            .irq_src      (irq_src[f*NUM_IRQ +: NUM_IRQ]),
            .strb         (strb[f]),
            .wd_wake      (reg_wdata[WAKE_BIT]),
            .wd_master    (reg_wdata[MASTER_BIT]),
            .wd_intr      (reg_wdata[INTR_BIT]),
            .evt          (evt[f]),
            .mask         (mask[f]),
            .src_lat      (src_lat[f]),
            .stschg       (stschg[f]),
            .intr_pend    (intr_pend[f])
        );

        always_comb begin
            slot_rd[f] = '0;
            if (hit[f]) begin
                unique case (sel)
                    SEL_EVENT: slot_rd[f] = pack_event(evt[f]);
                    SEL_MASK:  slot_rd[f] = pack_mask(mask[f]);
                    SEL_SRC:   slot_rd[f] = pack_src(src_lat[f]);
                    SEL_PTR:   slot_rd[f] = pointer_word(SLOT_OFF);
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int f = 0; f < NUM_FUNC; f++)
            reg_rdata = reg_rdata | slot_rd[f];
    end

    always_comb begin
        if (!por_rst)
            assert_one_slot_R12: assert ($onehot0(hit))
                else $error("address decodes to several functions");
    end

    assert_cardbus_gate_R10: assert property (@(posedge clk) disable iff (por_rst)
        !cardbus_mode |-> (stschg == '0))
        else $error("status change outside CardBus mode");

endmodule

// File: tb/fe_event_bank_bench.sv
module fe_event_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NF = 3;

    logic              clk = 1'b0;
    logic              por_rst = 1'b1;
    logic              bus_rst = 1'b0;
    logic              sys_rst = 1'b0;
    logic              cardbus_mode = 1'b0;
    logic [NF-1:0]     aud_wake = '0, aud_wake_en = '0, gpio_wake = '0, gpio_wake_en = '0;
    logic [NF*4-1:0]   irq_src = '0;
    logic              reg_wr = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic [NF-1:0]     stschg, intr_pend;

    int n_tests = 0;
    int n_fail  = 0;

    fe_event_bank u_fe_event_bank (
        .clk(clk), .por_rst(por_rst), .bus_rst(bus_rst), .sys_rst(sys_rst),
        .cardbus_mode(cardbus_mode), .aud_wake(aud_wake), .aud_wake_en(aud_wake_en),
        .gpio_wake(gpio_wake), .gpio_wake_en(gpio_wake_en), .irq_src(irq_src),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .stschg(stschg), .intr_pend(intr_pend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] slot(input int f, input int r);
        return 12'(32'h100 + 16 * f + r);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_rst(input int which);
        @(negedge clk);
        if (which == 0) por_rst = 1'b1;
        if (which == 1) bus_rst = 1'b1;
        if (which == 2) sys_rst = 1'b1;
        @(negedge clk);
        por_rst = 1'b0; bus_rst = 1'b0; sys_rst = 1'b0;
    endtask

    task automatic pulse_irq(input int f, input logic [3:0] bits);
        @(negedge clk);
        irq_src[f*4 +: 4] = bits;
        @(negedge clk);
        irq_src = '0;
    endtask

    task automatic pulse_aud(input int f, input logic en);
        @(negedge clk);
        aud_wake[f] = 1'b1; aud_wake_en[f] = en;
        @(negedge clk);
        aud_wake = '0; aud_wake_en = '0;
    endtask

    task automatic t_reset_map;
        logic [15:0] d;
        for (int f = 0; f < NF; f++) begin
            rd(slot(f, 0), d);  chk("R2 event after por", d, 16'h0000);
            rd(slot(f, 4), d);  chk("R2 mask after por", d, 16'h0000);
            rd(slot(f, 8), d);  chk("R2 src after por", d, 16'h0000);
            rd(slot(f, 12), d); chk("R1 pointer word", d, 16'(16'h101 + 16 * f));
        end
        chk("R10 stschg after por", {13'd0, stschg}, 16'h0);
        rd(12'h130, d); chk("R1 unmapped slot", d, 16'h0);
        rd(12'h102, d); chk("R1 unaligned offset", d, 16'h0);
    endtask

    task automatic t_reserved;
        logic [15:0] d;
        wr(slot(1, 4), 16'hFFFF);
        rd(slot(1, 4), d); chk("R2 mask reserved bits", d, 16'hC010);
        rd(slot(0, 4), d); chk("R12 f0 mask untouched", d, 16'h0000);
        rd(slot(2, 4), d); chk("R12 f2 mask untouched", d, 16'h0000);
        wr(12'h134, 16'hFFFF);
        rd(slot(2, 4), d); chk("R1 write to unmapped slot", d, 16'h0000);
        wr(slot(1, 4), 16'h0000);
        rd(slot(1, 4), d); chk("R2 mask write zero", d, 16'h0000);
    endtask

    task automatic t_wake;
        logic [15:0] d;
        pulse_aud(0, 1'b0);
        rd(slot(0, 0), d); chk("R3 audio without enable", d, 16'h0000);
        @(negedge clk); gpio_wake[0] = 1'b1;
        @(negedge clk); gpio_wake = '0;
        rd(slot(0, 0), d); chk("R3 gpio without enable", d, 16'h0000);
        pulse_aud(0, 1'b1);
        rd(slot(0, 0), d); chk("R3 audio with enable", d, 16'h0010);
        rd(slot(1, 0), d); chk("R12 f1 event untouched", d, 16'h0000);
        wr(slot(0, 0), 16'h7FEF);
        rd(slot(0, 0), d); chk("R4 write zero keeps pending", d, 16'h0010);
        wr(slot(0, 0), 16'h0010);
        rd(slot(0, 0), d); chk("R4 write one clears", d, 16'h0000);
        @(negedge clk); gpio_wake[2] = 1'b1; gpio_wake_en[2] = 1'b1;
        @(negedge clk); gpio_wake = '0; gpio_wake_en = '0;
        rd(slot(2, 0), d); chk("R3 gpio with enable", d, 16'h0010);
        wr(slot(2, 0), 16'h0010);
    endtask

    task automatic t_stschg;
        pulse_aud(1, 1'b1);
        wr(slot(1, 4), 16'h4010);
        cardbus_mode = 1'b1; #1;
        chk("R10 all enables", {13'd0, stschg}, 16'h0002);
        cardbus_mode = 1'b0; #1;
        chk("R10 not cardbus", {13'd0, stschg}, 16'h0000);
        cardbus_mode = 1'b1;
        wr(slot(1, 4), 16'h0010); #1;
        chk("R10 master off", {13'd0, stschg}, 16'h0000);
        wr(slot(1, 4), 16'h4000); #1;
        chk("R10 wake mask off", {13'd0, stschg}, 16'h0000);
        wr(slot(1, 4), 16'h4010);
        wr(slot(1, 0), 16'h0010); #1;
        chk("R10 pending cleared", {13'd0, stschg}, 16'h0000);
        cardbus_mode = 1'b0;
        wr(slot(1, 4), 16'h0000);
    endtask

    task automatic t_irq;
        logic [15:0] d;
        wr(slot(2, 4), 16'h8000);
        pulse_irq(2, 4'b0100);
        rd(slot(2, 8), d); chk("R7 latch 2 at bit 14", d, 16'h4000);
        rd(slot(2, 0), d); chk("R6 event bit 15 masked on", d, 16'h8000);
        chk("R6 intr_pend out", {13'd0, intr_pend}, 16'h0004);
        wr(slot(2, 4), 16'h0000);
        rd(slot(2, 0), d); chk("R6 mask off hides pending", d, 16'h0000);
        rd(slot(2, 8), d); chk("R6 latch kept under mask", d, 16'h4000);
        pulse_irq(2, 4'b1001);
        rd(slot(2, 8), d); chk("R7 latches accumulate", d, 16'hD000);
        wr(slot(2, 0), 16'h0000);
        rd(slot(2, 8), d); chk("R7 write zero keeps latches", d, 16'hD000);
        wr(slot(2, 0), 16'h8000);
        rd(slot(2, 8), d); chk("R7 write one clears all", d, 16'h0000);
    endtask

    task automatic t_resets;
        logic [15:0] d;
        pulse_aud(0, 1'b1);
        wr(slot(0, 4), 16'hC010);
        pulse_irq(0, 4'b0011);
        pulse_rst(2);
        rd(slot(0, 0), d); chk("R5 sys keeps wake pending", d, 16'h0010);
        rd(slot(0, 4), d); chk("R9 sys clears masks, R5 keeps master", d, 16'h4000);
        rd(slot(0, 8), d); chk("R8 sys keeps latches", d, 16'h3000);
        wr(slot(0, 4), 16'hC010);
        pulse_rst(1);
        rd(slot(0, 0), d); chk("R5 bus keeps wake pending", d, 16'h0010);
        rd(slot(0, 4), d); chk("R9 bus clears masks, R5 keeps master", d, 16'h4000);
        rd(slot(0, 8), d); chk("R8 bus clears latches", d, 16'h0000);
        pulse_irq(0, 4'b0001);
        pulse_rst(0);
        rd(slot(0, 0), d); chk("R5 por clears wake pending", d, 16'h0000);
        rd(slot(0, 4), d); chk("R5 por clears master", d, 16'h0000);
        rd(slot(0, 8), d); chk("R8 por clears latches", d, 16'h0000);
    endtask

    task automatic t_collide;
        logic [15:0] d;
        pulse_aud(1, 1'b1);
        @(negedge clk);
        aud_wake[1] = 1'b1; aud_wake_en[1] = 1'b1;
        reg_addr = slot(1, 0); reg_wdata = 16'h0010; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; aud_wake = '0; aud_wake_en = '0;
        rd(slot(1, 0), d); chk("R11 wake set beats clear", d, 16'h0010);
        wr(slot(1, 0), 16'h0010);
        rd(slot(1, 0), d); chk("R11 wake clears afterwards", d, 16'h0000);
        pulse_irq(1, 4'b0110);
        @(negedge clk);
        irq_src[7:4] = 4'b0100;
        reg_addr = slot(1, 0); reg_wdata = 16'h8000; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; irq_src = '0;
        rd(slot(1, 8), d); chk("R11 source beats clear", d, 16'h4000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        t_reset_map();
        t_reserved();
        t_wake();
        t_stschg();
        t_irq();
        t_resets();
        t_collide();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule